// File: doc/BRIEF.md
# Display Control Command Decoder

This block takes 32-bit writes to a display control port. The top byte of each word is a command number and the lower 24 bits are its operand. The block keeps a 32-bit status word, the display start position in frame memory, the horizontal and vertical display spans, and the video mode bits. From the mode bits it derives the active horizontal pixel count and the dot-clock divider.

A group of query commands copies a masked view of one of the drawing-environment registers into a 32-bit read-back register. The block emits two single-cycle pulses: one for a full reset and one that tells the command path to drop queued words and abort any unfinished pixel transfer. Rendering, scan-out and screen centering belong to other blocks.

Every write takes effect on the clock edge that samples the strobe. Both the new register values and any pulse appear in the cycle that follows.

Top module: `dispctl_decoder`

## Requirements
- R1: After `rst_n` is released, `status` reads 0x14802000. The start position, both spans and `readback` read 0, and both pulses are low.
- R2: Command 0x00 restores the complete R1 state one cycle after the strobe, and `full_rst_pulse` is high in that cycle only.
- R3: Command 0x01 raises `path_rst_pulse` for one cycle. It changes no register.
- R4: Command 0x03 sets the blanking flag, status bit 23, when data bit 0 is 1 and clears it when data bit 0 is 0.
- R5: Command 0x04 writes data[1:0] into the transfer-direction field, status bits 30:29.
- R6: Command 0x05 loads start X from data[9:0] and start Y from data[18:10].
- R7: Command 0x06 loads the horizontal span start from data[11:0] and its end from data[23:12]. Command 0x07 loads the vertical span start from data[9:0] and its end from data[19:10].
- R8: Command 0x08 writes data[5:0] to status bits 22:17 and data[6] to status bit 16. It leaves all other status bits unchanged.
- R9: Commands 0x10 to 0x1F are queries, with data[3:0] as the index. Indices 2, 3 and 4 load `readback` with that environment register ANDed with 0x000FFFFF. Index 5 loads environment register 5 ANDed with 0x003FFFFF.
- R10: Query index 7 loads `readback` with the value 2. Any other index not covered by R9 leaves `readback` unchanged.
- R11: The mode code status[18:16], values 0 to 7, selects a pixel width of 256, 368, 320, 368, 512, 368, 640, 368 and a dot-clock divider of 10, 7, 8, 7, 5, 7, 4, 7.
- R12: Command numbers not listed above, such as 0x02, 0x09 and 0x20, change no register and raise no pulse.
- R13: While `wr_en` is low, the value on `wr_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 32 | Command byte and operand |
| env_regs | input | ENV_NUM*32 | Drawing-environment registers, index 0 in the lowest word |
| status | output | 32 | Status word |
| readback | output | 32 | Query result register |
| start_x | output | 10 | Display start X |
| start_y | output | 9 | Display start Y |
| hspan_beg | output | 12 | Horizontal span start |
| hspan_end | output | 12 | Horizontal span end |
| vspan_beg | output | 10 | Vertical span start |
| vspan_end | output | 10 | Vertical span end |
| line_px | output | 10 | Pixel width for the current mode code |
| dot_div | output | 4 | Dot-clock divider for the current mode code |
| full_rst_pulse | output | 1 | One-cycle full reset pulse |
| path_rst_pulse | output | 1 | One-cycle command-path reset pulse |

## Verification
Operands are chosen with every field at full width and with neighbouring bits set. This exposes a field taken from the wrong position or truncated, for example a start Y that picks up bit 9 or misses bit 18. Mode writes step through several codes, including ones that set only bit 6 or only bits 0 and 1, which tells the packing of status bit 16 apart from bits 22:17. Environment registers hold all-ones upper bits so that each query mask width is visible. Queries with unused indices, unlisted commands and data driven with the strobe low show that the registers stay unchanged.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

   localparam logic [7:0] OP_FULL_RST = 8'h00;
   localparam logic [7:0] OP_PATH_RST = 8'h01;
   localparam logic [7:0] OP_BLANK    = 8'h03;
   localparam logic [7:0] OP_DMA_DIR  = 8'h04;
   localparam logic [7:0] OP_ORIGIN   = 8'h05;
   localparam logic [7:0] OP_HSPAN    = 8'h06;
   localparam logic [7:0] OP_VSPAN    = 8'h07;
   localparam logic [7:0] OP_MODE     = 8'h08;
   localparam logic [3:0] OP_QUERY_HI = 4'h1;

   localparam int BLANK_BIT = 23;
   localparam int DMA_LO    = 29;
   localparam int MODE_LO   = 16;
   localparam int MODE_HI   = 22;

   localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

   typedef struct packed {
      logic full_rst;
      logic path_rst;
      logic blank;
      logic dma;
      logic origin;
      logic hspan;
      logic vspan;
      logic mode;
      logic query;
   } op_strobe_t;

   // odd codes share one width; even codes pick one of four
   function automatic logic [9:0] mode_px(input logic [2:0] code);
      logic [9:0] r;
      if (code[0]) r = 10'd368;
      else begin
         case (code[2:1])
            2'd0:    r = 10'd256;
            2'd1:    r = 10'd320;
            2'd2:    r = 10'd512;
            default: r = 10'd640;
         endcase
      end
      return r;
   endfunction

   function automatic logic [3:0] mode_div(input logic [2:0] code);
      logic [3:0] r;
      if (code[0]) r = 4'd7;
      else begin
         case (code[2:1])
            2'd0:    r = 4'd10;
            2'd1:    r = 4'd8;
            2'd2:    r = 4'd5;
            default: r = 4'd4;
         endcase
      end
      return r;
   endfunction

   function automatic logic [31:0] env_mask(input int idx);
      logic [31:0] m;
      if (idx >= 2 && idx <= 4) m = 32'h000F_FFFF;
      else if (idx == 5)        m = 32'h003F_FFFF;
      else                      m = 32'h0;
      return m;
   endfunction

endpackage

// File: rtl/dispctl_op_decode.sv
module dispctl_op_decode
   import dispctl_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output op_strobe_t    strb
);
   localparam int OP_LO = DW - 8;

   logic [7:0] op;
   assign op = wr_data[DW-1:OP_LO];

   always_comb begin
      strb          = '0;
      strb.full_rst = wr_en && (op == OP_FULL_RST);
      strb.path_rst = wr_en && (op == OP_PATH_RST);
      strb.blank    = wr_en && (op == OP_BLANK);
      strb.dma      = wr_en && (op == OP_DMA_DIR);
      strb.origin   = wr_en && (op == OP_ORIGIN);
      strb.hspan    = wr_en && (op == OP_HSPAN);
      strb.vspan    = wr_en && (op == OP_VSPAN);
      strb.mode     = wr_en && (op == OP_MODE);
      strb.query    = wr_en && (op[7:4] == OP_QUERY_HI);
   end
endmodule

// File: rtl/dispctl_query.sv
module dispctl_query
   import dispctl_pkg::*;
#(
   parameter int DW      = 32,
   parameter int ENV_NUM = 8
) (
   input  logic [ENV_NUM*DW-1:0] env_regs,
   input  logic [3:0]            sel,
   output logic                  hit,
   output logic [DW-1:0]         value
);
   logic [DW-1:0] masked [ENV_NUM];

   for (genvar i = 0; i < ENV_NUM; i++) begin : g_mask
      localparam logic [31:0] MSK = env_mask(i);
      assign masked[i] = env_regs[i*DW +: DW] & MSK[DW-1:0];
   end

   always_comb begin
      hit   = 1'b1;
      value = '0;
      case (sel)
         4'd2:    value = masked[2];
         4'd3:    value = masked[3];
         4'd4:    value = masked[4];
         4'd5:    value = masked[5];
         4'd7:    value = DW'(2);
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/dispctl_hres.sv
module dispctl_hres
   import dispctl_pkg::*;
(
   input  logic [2:0] code,
   output logic [9:0] px,
   output logic [3:0] div
);
   always_comb begin
      px  = mode_px(code);
      div = mode_div(code);
   end
endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder
   import dispctl_pkg::*;
#(
   parameter int DW      = 32,
   parameter int ENV_NUM = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [DW-1:0]         wr_data,
   input  logic [ENV_NUM*DW-1:0] env_regs,
   output logic [DW-1:0]         status,
   output logic [DW-1:0]         readback,
   output logic [9:0]            start_x,
   output logic [8:0]            start_y,
   output logic [11:0]           hspan_beg,
   output logic [11:0]           hspan_end,
   output logic [9:0]            vspan_beg,
   output logic [9:0]            vspan_end,
   output logic [9:0]            line_px,
   output logic [3:0]            dot_div,
   output logic                  full_rst_pulse,
   output logic                  path_rst_pulse
);
   localparam int MODE_W = MODE_HI - MODE_LO + 1;

   if (DW != 32) begin : g_bad_dw
      $error("dispctl_decoder: DW must be 32");
   end
   if (ENV_NUM < 6) begin : g_bad_env
      $error("dispctl_decoder: ENV_NUM must be at least 6");
   end

   op_strobe_t    strb;
   logic          q_hit;
   logic [DW-1:0] q_val;

   dispctl_op_decode #(.DW(DW)) u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .strb    (strb)
   );

   dispctl_query #(.DW(DW), .ENV_NUM(ENV_NUM)) u_qry (
      .env_regs (env_regs),
      .sel      (wr_data[3:0]),
      .hit      (q_hit),
      .value    (q_val)
   );

   dispctl_hres u_hres (
      .code (status[MODE_LO+2:MODE_LO]),
      .px   (line_px),
      .div  (dot_div)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || strb.full_rst) begin
         status    <= STATUS_INIT[DW-1:0];
         readback  <= '0;
         start_x   <= '0;
         start_y   <= '0;
         hspan_beg <= '0;
         hspan_end <= '0;
         vspan_beg <= '0;
         vspan_end <= '0;
      end else begin
         if (strb.blank)  status[BLANK_BIT] <= wr_data[0];
         if (strb.dma)    status[DMA_LO+1:DMA_LO] <= wr_data[1:0];
         if (strb.mode)   status[MODE_HI:MODE_LO] <= {wr_data[MODE_W-2:0], wr_data[MODE_W-1]};
         if (strb.origin) begin
            start_x <= wr_data[9:0];
            start_y <= wr_data[18:10];
         end
         if (strb.hspan) begin
            hspan_beg <= wr_data[11:0];
            hspan_end <= wr_data[23:12];
         end
         if (strb.vspan) begin
            vspan_beg <= wr_data[9:0];
            vspan_end <= wr_data[19:10];
         end
         if (strb.query && q_hit) readback <= q_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_rst_pulse <= 1'b0;
         path_rst_pulse <= 1'b0;
      end else begin
         full_rst_pulse <= strb.full_rst;
         path_rst_pulse <= strb.path_rst;
      end
   end
endmodule

// File: rtl/dispctl_decoder_chk.sv
module dispctl_decoder_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [DW-1:0] wr_data,
   input logic [DW-1:0] status,
   input logic [DW-1:0] readback,
   input logic [9:0]    start_x,
   input logic [8:0]    start_y,
   input logic          full_rst_pulse,
   input logic          path_rst_pulse
);
   logic [7:0] op;
   assign op = wr_data[DW-1:DW-8];

   // R2
   p_full_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == 8'h00) |=> (full_rst_pulse && status == 32'h1480_2000 && readback == '0));
   // R2
   p_full_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst_pulse |-> $past(wr_en && op == 8'h00));
   // R3
   p_path_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == 8'h01) |=> (path_rst_pulse && $stable(status) && $stable(readback)));
   // R2, R3
   p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({full_rst_pulse, path_rst_pulse}));
   // R4
   p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == 8'h03) |=> status[23] == $past(wr_data[0]));
   // R5
   p_dma_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == 8'h04) |=> status[30:29] == $past(wr_data[1:0]));
   // R6
   p_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == 8'h05) |=> (start_x == $past(wr_data[9:0]) && start_y == $past(wr_data[18:10])));
   // R8
   p_mode_pack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == 8'h08) |=> (status[22:16] == {$past(wr_data[5:0]), $past(wr_data[6])}
                                  && status[15:0] == $past(status[15:0])));
   // R13
   p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(status) && $stable(readback) && !full_rst_pulse && !path_rst_pulse));
endmodule

bind dispctl_decoder dispctl_decoder_chk #(.DW(DW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_data        (wr_data),
   .status         (status),
   .readback       (readback),
   .start_x        (start_x),
   .start_y        (start_y),
   .full_rst_pulse (full_rst_pulse),
   .path_rst_pulse (path_rst_pulse)
);

// File: tb/dispctl_decoder_test.sv
module dispctl_decoder_test;
   localparam int DW = 32;
   localparam int EN = 8;

   typedef struct {
      string       req;
      int          due;
      logic [31:0] st, rb;
      logic [9:0]  x;
      logic [8:0]  y;
      logic [11:0] hb, he;
      logic [9:0]  vb, ve, px;
      logic [3:0]  dv;
      logic        fp, pp;
   } snap_t;

   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [EN*DW-1:0] env_regs;
   logic [31:0] status, readback;
   logic [9:0] start_x, vspan_beg, vspan_end, line_px;
   logic [8:0] start_y;
   logic [11:0] hspan_beg, hspan_end;
   logic [3:0] dot_div;
   logic full_rst_pulse, path_rst_pulse;

   int total = 0, bad = 0, cyc = 0;
   snap_t exp_q[$];
   snap_t m;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dispctl_decoder #(.DW(DW), .ENV_NUM(EN)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .env_regs(env_regs),
      .status(status), .readback(readback), .start_x(start_x), .start_y(start_y),
      .hspan_beg(hspan_beg), .hspan_end(hspan_end), .vspan_beg(vspan_beg),
      .vspan_end(vspan_end), .line_px(line_px), .dot_div(dot_div),
      .full_rst_pulse(full_rst_pulse), .path_rst_pulse(path_rst_pulse));

   function automatic void model_px(input logic [2:0] c, output logic [9:0] p, output logic [3:0] d);
      case (c)
         3'd0: begin p = 256; d = 10; end
         3'd2: begin p = 320; d = 8;  end
         3'd4: begin p = 512; d = 5;  end
         3'd6: begin p = 640; d = 4;  end
         default: begin p = 368; d = 7; end
      endcase
   endfunction

   task automatic model_reset();
      m.st = 32'h1480_2000; m.rb = 0; m.x = 0; m.y = 0;
      m.hb = 0; m.he = 0; m.vb = 0; m.ve = 0;
      m.fp = 0; m.pp = 0;
      model_px(3'd0, m.px, m.dv);
   endtask

   task automatic compare(input snap_t e);
      total++;
      if (status !== e.st || readback !== e.rb || start_x !== e.x || start_y !== e.y ||
          hspan_beg !== e.hb || hspan_end !== e.he || vspan_beg !== e.vb || vspan_end !== e.ve ||
          line_px !== e.px || dot_div !== e.dv || full_rst_pulse !== e.fp || path_rst_pulse !== e.pp) begin
         bad++;
         $display("FAIL %s: got st=%h rb=%h x=%0d y=%0d h=%0d/%0d v=%0d/%0d px=%0d dv=%0d fp=%b pp=%b exp st=%h rb=%h x=%0d y=%0d h=%0d/%0d v=%0d/%0d px=%0d dv=%0d fp=%b pp=%b",
            e.req, status, readback, start_x, start_y, hspan_beg, hspan_end, vspan_beg, vspan_end,
            line_px, dot_div, full_rst_pulse, path_rst_pulse,
            e.st, e.rb, e.x, e.y, e.hb, e.he, e.vb, e.ve, e.px, e.dv, e.fp, e.pp);
      end
   endtask

   // monitor: compare each expected item in the cycle after its write
   always @(negedge clk) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) compare(exp_q.pop_front());
   end

   task automatic drive(input string req, input logic en, input logic [31:0] d);
      logic [7:0] op;
      logic [EN*DW-1:0] ev;
      @(negedge clk);
      wr_en = en; wr_data = d;
      op = d[31:24]; ev = env_regs;
      m.fp = 0; m.pp = 0;
      if (en) begin
         if (op == 8'h00) begin model_reset(); m.fp = 1; end
         else if (op == 8'h01) m.pp = 1;
         else if (op == 8'h03) m.st[23] = d[0];
         else if (op == 8'h04) m.st[30:29] = d[1:0];
         else if (op == 8'h05) begin m.x = d[9:0]; m.y = d[18:10]; end
         else if (op == 8'h06) begin m.hb = d[11:0]; m.he = d[23:12]; end
         else if (op == 8'h07) begin m.vb = d[9:0]; m.ve = d[19:10]; end
         else if (op == 8'h08) begin m.st[22:17] = d[5:0]; m.st[16] = d[6]; end
         else if (op[7:4] == 4'h1) begin
            case (d[3:0])
               4'd2, 4'd3, 4'd4: m.rb = ev[d[2:0]*32 +: 32] & 32'h000F_FFFF;
               4'd5: m.rb = ev[5*32 +: 32] & 32'h003F_FFFF;
               4'd7: m.rb = 32'd2;
               default: ;
            endcase
         end
      end
      model_px(m.st[18:16], m.px, m.dv);
      m.req = req; m.due = cyc + 1;
      exp_q.push_back(m);
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      for (int i = 0; i < EN; i++) env_regs[i*32 +: 32] = 32'hFFF0_0000 | (32'h13579 * (i + 1));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      m.req = "R1 reset state"; compare(m);
      drive("R4 blank clear", 1, 32'h0300_0000);
      drive("R4 blank set",   1, 32'h0300_0001);
      drive("R5 dma dir 3",   1, 32'h0400_0003);
      drive("R5 dma dir 2",   1, 32'h04FF_FFFE);
      drive("R6 origin",      1, 32'h0507_FFFF);
      drive("R6 origin y",    1, 32'h0504_0155);
      drive("R7 hspan",       1, 32'h06C8_0260);
      drive("R7 vspan",       1, 32'h07F0_3C10);
      drive("R8 R11 mode 1",  1, 32'h0800_0040);
      drive("R8 R11 mode 2",  1, 32'h0800_0001);
      drive("R8 R11 mode 4",  1, 32'h0800_0002);
      drive("R8 R11 mode 6",  1, 32'h0800_0003);
      drive("R8 R11 mode 7",  1, 32'h0800_007B);
      drive("R8 R11 mode 0",  1, 32'h0800_0000);
      drive("R9 query 2",     1, 32'h1000_0002);
      drive("R9 query 3",     1, 32'h1F00_0003);
      drive("R9 query 4",     1, 32'h1000_0004);
      drive("R9 query 5",     1, 32'h1000_0005);
      drive("R10 query 7",    1, 32'h1000_0007);
      drive("R10 query 6 kept", 1, 32'h1000_0006);
      drive("R10 query 0 kept", 1, 32'h1000_0000);
      drive("R10 query 15 kept", 1, 32'h1A00_000F);
      drive("R3 path reset",  1, 32'h0100_0000);
      drive("R12 op 02",      1, 32'h02FF_FFFF);
      drive("R12 op 09",      1, 32'h09FF_FFFF);
      drive("R12 op 20",      1, 32'h20FF_FFFF);
      drive("R13 idle reset", 0, 32'h0000_0000);
      drive("R13 idle origin", 0, 32'h0500_0123);
      drive("R13 idle query", 0, 32'h1000_0005);
      drive("R2 full reset",  1, 32'h00AB_CDEF);
      drive("R2 pulse drop",  0, 32'h0);
      drive("R8 after reset", 1, 32'h0800_0041);
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R1..: %0d expected items left, expected 0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule